// File: doc/BRIEF.md
# Banked Indirect Address Generator

This block holds four 16-bit pointer registers and forms a 24-bit effective address from one of them. The selected pointer supplies the low sixteen bits of the address. An 8-bit bank value, chosen by the pointer index, supplies the top eight bits. Pointers 0 and 1 take the data bank. Pointer 2 takes the extra data bank. Pointer 3 takes the system stack bank or the user stack bank, as a select input decides.

In plain mode the pointer is only read. In post-increment mode the access uses the pointer's present value. When the access-done strobe arrives, the pointer then advances by the operand size: 1, 2 or 4. The advance wraps within sixteen bits. Execution may also write any pointer directly in the same cycle. When that write hits the pointer being advanced, the written data is stored and the increment is dropped. The address is combinational from the current inputs, and all pointer updates land on the next rising clock edge.

Top module: `ind_addr_gen`

## Requirements
- R1: `ea_o[15:0]` equals the pointer selected by `ptr_sel_i`, in both modes, as a combinational function of the current state and inputs.
- R2: `ea_o[23:16]` equals `dbank_i` when `ptr_sel_i` is 0 or 1.
- R3: `ea_o[23:16]` equals `xbank_i` when `ptr_sel_i` is 2.
- R4: When `ptr_sel_i` is 3, `ea_o[23:16]` equals `sbank_i` if `stk_user_i` is 0 and `ubank_i` if `stk_user_i` is 1.
- R5: With `mode_i`=1 (post-increment) and `done_i`=1, the selected pointer becomes its old value plus the step on the next clock edge. The step is set by `size_i`: 0 gives 1 (byte), 1 gives 2 (word), 2 or 3 gives 4 (long word). `ea_o` in that cycle still shows the old value.
- R6: The increment wraps modulo 2^16. It changes neither `ea_o[23:16]` nor any other pointer.
- R7: With `mode_i`=0 (plain), or with `done_i`=0, no pointer changes unless it is written through `wr_en_i`.
- R8: With `wr_en_i`=1, pointer `wr_idx_i` takes `wr_data_i` on the next clock edge. When it is also the pointer being incremented, the written data wins.
- R9: A synchronous reset `rst_i` clears all four pointers to zero.
- R10: With pointer 1 = 16'hD30F and `dbank_i` = 8'h78, selecting pointer 1 gives `ea_o` = 24'h78D30F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ptr_sel_i | input | 2 | Index of the pointer used for the access |
| mode_i | input | 1 | 0 plain indirect, 1 post-increment |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long word |
| stk_user_i | input | 1 | Stack bank choice for pointer 3: 0 system, 1 user |
| done_i | input | 1 | Access complete; enables post-increment writeback |
| dbank_i | input | 8 | Data bank value |
| xbank_i | input | 8 | Additional data bank value |
| sbank_i | input | 8 | System stack bank value |
| ubank_i | input | 8 | User stack bank value |
| wr_en_i | input | 1 | Instruction write to a pointer |
| wr_idx_i | input | 2 | Index of the pointer written |
| wr_data_i | input | 16 | Data written to the pointer |
| ea_o | output | 24 | Effective address |
| ptr_o | output | 64 | Pointer file, pointer k in bits 16k+15:16k |

## Verification
The hardest case to reach is a collision. It needs a post-increment with the done strobe in the same cycle as an instruction write to the same pointer, and ideally with the pointer close to 16'hFFFF so that wrap and override meet. Random stimulus alone reaches this rarely. The bench therefore draws the write index from the selected pointer with raised probability. It also adds directed cycles that load 16'hFFFE or 16'hFFFF through the write port and then increment with every size, with and without a colliding write. A reference pointer file kept by bench functions predicts every edge.

// File: rtl/ind_addr_gen.sv
module ind_addr_gen #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned NP = 4,
  localparam int unsigned IW = $clog2(NP)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [IW-1:0]    ptr_sel_i,
  input  logic             mode_i,
  input  logic [1:0]       size_i,
  input  logic             stk_user_i,
  input  logic             done_i,
  input  logic [BW-1:0]    dbank_i,
  input  logic [BW-1:0]    xbank_i,
  input  logic [BW-1:0]    sbank_i,
  input  logic [BW-1:0]    ubank_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [AW-1:0]    wr_data_i,
  output logic [AW+BW-1:0] ea_o,
  output logic [NP*AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q [NP];
  logic [AW-1:0] cur;
  logic [AW-1:0] step;
  logic [BW-1:0] bank;
  logic          inc_go;

  assign cur    = ptr_q[ptr_sel_i];
  assign inc_go = mode_i & done_i;

  always_comb begin
    unique case (size_i)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  always_comb begin
    unique case (ptr_sel_i)
      2'd0, 2'd1: bank = dbank_i;
      2'd2:       bank = xbank_i;
      default:    bank = stk_user_i ? ubank_i : sbank_i;
    endcase
  end

  assign ea_o = {bank, cur};

  for (genvar k = 0; k < NP; k++) begin : g_ptr
    always_ff @(posedge clk_i) begin
      if (rst_i)
        ptr_q[k] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(k))
        ptr_q[k] <= wr_data_i;
      else if (inc_go && ptr_sel_i == IW'(k))
        ptr_q[k] <= ptr_q[k] + step;
    end
    assign ptr_o[k*AW +: AW] = ptr_q[k];
  end

  AST_EA_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    ea_o[AW-1:0] == ptr_o[ptr_sel_i*AW +: AW]); // R1
  AST_BANK_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
    (ptr_sel_i < 2) |-> ea_o[AW+BW-1:AW] == dbank_i); // R2
  AST_BANK_EXTRA: assert property (@(posedge clk_i) disable iff (rst_i)
    (ptr_sel_i == 2) |-> ea_o[AW+BW-1:AW] == xbank_i); // R3
  AST_BANK_STACK: assert property (@(posedge clk_i) disable iff (rst_i)
    (ptr_sel_i == 3) |-> ea_o[AW+BW-1:AW] == (stk_user_i ? ubank_i : sbank_i)); // R4
  AST_POST_INC: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i && done_i && !(wr_en_i && wr_idx_i == ptr_sel_i)) |=>
      ptr_o[$past(ptr_sel_i)*AW +: AW] ==
        AW'($past(ea_o[AW-1:0]) + ($past(size_i) == 0 ? 1 : $past(size_i) == 1 ? 2 : 4))); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !(mode_i && done_i) && !wr_en_i |=> $stable(ptr_o)); // R7
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> ptr_o[$past(wr_idx_i)*AW +: AW] == $past(wr_data_i)); // R8
  AST_RESET: assert property (@(posedge clk_i)
    rst_i |=> ptr_o == '0); // R9

endmodule

// File: tb/ind_addr_gen_tb.sv
module ind_addr_gen_tb;
  logic        clk_i = 0, rst_i = 1;
  logic [1:0]  ptr_sel_i = 0, size_i = 0, wr_idx_i = 0;
  logic        mode_i = 0, stk_user_i = 0, done_i = 0, wr_en_i = 0;
  logic [7:0]  dbank_i = 0, xbank_i = 0, sbank_i = 0, ubank_i = 0;
  logic [15:0] wr_data_i = 0;
  logic [23:0] ea_o;
  logic [63:0] ptr_o;

  int checks = 0, errors = 0;
  logic [15:0] ref_p [4];

  always #5 clk_i = ~clk_i;

  ind_addr_gen u_dut (.*);

  function automatic logic [15:0] step_of(logic [1:0] s);
    return s == 0 ? 16'd1 : s == 1 ? 16'd2 : 16'd4;
  endfunction

  function automatic logic [7:0] bank_of(logic [1:0] p, logic u, logic [7:0] d,
                                         logic [7:0] x, logic [7:0] s, logic [7:0] us);
    return p < 2 ? d : p == 2 ? x : (u ? us : s);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, ea_o, {bank_of(ptr_sel_i, stk_user_i, dbank_i, xbank_i, sbank_i, ubank_i),
                    ref_p[ptr_sel_i]});
    chk(req, ptr_o, {ref_p[3], ref_p[2], ref_p[1], ref_p[0]});
  endtask

  task automatic clock_in();
    logic [15:0] o;
    o = ref_p[ptr_sel_i];
    @(posedge clk_i);
    if (mode_i && done_i) ref_p[ptr_sel_i] = o + step_of(size_i);
    if (wr_en_i) ref_p[wr_idx_i] = wr_data_i;
    #2;
  endtask

  task automatic wr(logic [1:0] i, logic [15:0] d);
    mode_i = 0; done_i = 0; wr_en_i = 1; wr_idx_i = i; wr_data_i = d;
    clock_in();
    wr_en_i = 0;
  endtask

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) ref_p[i] = 0;
    dbank_i = 8'h78; xbank_i = 8'h11; sbank_i = 8'h22; ubank_i = 8'h33;
    @(posedge clk_i); @(posedge clk_i); #2;
    rst_i = 0; #1;
    check_all("R9 reset");

    wr(2'd1, 16'hD30F);
    ptr_sel_i = 1; #1;
    chk("R10 example", ea_o, 24'h78D30F);
    check_all("R1 R2");

    wr(2'd2, 16'h0100); ptr_sel_i = 2; #1; check_all("R3");
    wr(2'd3, 16'h0200); ptr_sel_i = 3; stk_user_i = 0; #1; check_all("R4 sys");
    stk_user_i = 1; #1; check_all("R4 user");

    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 16'hFFFE);
      ptr_sel_i = 0; mode_i = 1; done_i = 1; size_i = s[1:0]; #1;
      chk("R5 old value", ea_o[15:0], 16'hFFFE);
      clock_in(); mode_i = 0; done_i = 0; #1;
      check_all("R5 R6 wrap");
    end

    wr(2'd3, 16'hFFFF);
    ptr_sel_i = 3; mode_i = 1; done_i = 1; size_i = 1;
    wr_en_i = 1; wr_idx_i = 3; wr_data_i = 16'hABCD;
    clock_in(); wr_en_i = 0; mode_i = 0; done_i = 0; #1;
    chk("R8 collision", ptr_o[63:48], 16'hABCD);

    ptr_sel_i = 2; mode_i = 1; done_i = 0; clock_in(); #1; check_all("R7 no done");
    mode_i = 0; done_i = 1; clock_in(); done_i = 0; #1; check_all("R7 plain");

    rst_i = 1; clock_in(); rst_i = 0;
    for (int i = 0; i < 4; i++) ref_p[i] = 0;
    #1; check_all("R9 reset again");

    for (int n = 0; n < 3000; n++) begin
      ptr_sel_i = 2'($urandom); mode_i = 1'($urandom); size_i = 2'($urandom);
      stk_user_i = 1'($urandom); done_i = 1'($urandom);
      dbank_i = 8'($urandom); xbank_i = 8'($urandom);
      sbank_i = 8'($urandom); ubank_i = 8'($urandom);
      wr_en_i = ($urandom % 4) == 0;
      wr_idx_i = ($urandom % 2) ? ptr_sel_i : 2'($urandom);
      wr_data_i = ($urandom % 3 == 0) ? 16'hFFFC + 16'($urandom % 4) : 16'($urandom);
      #1; check_all("R1 R2 R3 R4 random");
      clock_in();
      #1; check_all("R5 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule